// File: doc/BRIEF.md
# Complementary PWM Pair with Buffered Edge-XOR Combining

This block turns an edge-aligned PWM counter and two compare values (an even and an odd one) into one pair of gate-drive outputs, a high side and a low side. Each compare value produces its own raw pulse. An optional combining step merges the two raw pulses with an XOR before the complementary split and the deadtime insertion. Two compare values can then place a single pulse anywhere in the period, which is how phase-shifted waveforms are produced.

Software writes the combining bit into a buffer. The generator keeps using its current copy until a load-OK strobe has armed the block and a load-cycle marker then arrives. The readback always shows the buffered value. A mask input forces a zero-percent duty cycle. A mode input selects either complementary drive with deadtime or independent drive of the two outputs.

Top module: `pwm_xor_pair`

## Requirements
- R1: While reset is asserted and after its release, out_hi, out_lo and xor_rdbk are 0, the active combining bit is 0 and the block is not armed.
- R2: On each clock the block registers the even raw pulse (cnt_in >= val_even) and the odd raw pulse (cnt_in >= val_odd). Without combining, the generator pulse is even AND NOT odd. A change of cnt_in can reach the outputs at the second rising edge after it is sampled.
- R3: When compl_mode is 1 and the active combining bit is 1, the generator pulse is even XOR odd.
- R4: When compl_mode is 0, the combining bit has no effect. out_hi follows the generator pulse (even AND NOT odd) and out_lo follows the odd raw pulse, with no deadtime.
- R5: A cycle with xor_wr at 1 stores xor_wdata in the buffer, and xor_rdbk shows it after that edge. The write does not change the active bit.
- R6: The buffered bit moves to the active bit only on a cycle with load_cycle at 1 while the block is armed by an earlier ldok_set strobe. A load cycle that comes while the block is not armed changes nothing.
- R7: The armed state clears at the load cycle that does the transfer, so later load cycles transfer nothing until ldok_set comes again.
- R8: In complementary mode out_lo follows the inverted generator pulse. Each output falls at the first edge after its target goes low. Neither output rises until both have been low for max(deadtime,1) cycles.
- R9: While mask is 1 the generator pulse is 0: in complementary mode out_hi is low and out_lo goes high after deadtime; in independent mode both outputs are low.
- R10: out_hi and out_lo are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_in | input | CNT_W | Edge-aligned PWM counter value |
| val_even | input | CNT_W | Even compare value |
| val_odd | input | CNT_W | Odd compare value |
| xor_wr | input | 1 | Write strobe for the buffered combining bit |
| xor_wdata | input | 1 | Value written to the buffer |
| ldok_set | input | 1 | Arms the next load cycle |
| load_cycle | input | 1 | Marks the PWM load cycle |
| compl_mode | input | 1 | 1 = complementary with deadtime, 0 = independent |
| mask | input | 1 | Forces zero-percent duty |
| deadtime | input | DT_W | Deadtime in clock cycles |
| out_hi | output | 1 | High-side drive |
| out_lo | output | 1 | Low-side drive |
| xor_rdbk | output | 1 | Readback of the buffered combining bit |

## Verification
A stale or early-loaded active combining bit shows only when val_even is above val_odd. In that case plain generation keeps out_hi low for the whole period, and XOR combining produces a pulse from val_odd to val_even. The error therefore appears within one period after the load cycle concerned. A bad arming state appears the same way, at the next load cycle. A wrong deadtime count shifts a rising edge of out_hi or out_lo by whole cycles at the next transition, and a mixed-up buffer is visible on xor_rdbk one cycle after the write.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    // Buffered combining control: software copy, arming flag, generator copy
    typedef struct packed {
        logic buf_bit;
        logic armed;
        logic act;
    } edge_ctl_t;

    // Registered raw compare pulses
    typedef struct packed {
        logic even_p;
        logic odd_p;
    } raw_pulse_t;

endpackage

// File: rtl/pwm_edge_ctl.sv
module pwm_edge_ctl
    import pwm_pair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xor_wr,
    input  logic xor_wdata,
    input  logic ldok_set,
    input  logic load_cycle,
    output logic buf_bit,
    output logic act_bit
);

    edge_ctl_t st_d, st_q;
    logic      xfer;

    always_comb begin
        st_d = st_q;
        xfer = load_cycle && st_q.armed;
        if (xfer) begin
            st_d.act   = st_q.buf_bit;
            st_d.armed = 1'b0;
        end
        if (ldok_set) begin
            st_d.armed = 1'b1;
        end
        if (xor_wr) begin
            st_d.buf_bit = xor_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_bit = st_q.buf_bit;
    assign act_bit = st_q.act;

    // R5: buffer only moves on a write
    p_buf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !xor_wr |=> $stable(st_q.buf_bit));

    // R6: generator copy changes only at an armed load cycle
    p_act_at_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.act) |-> $past(load_cycle && st_q.armed));

    // R7: arming is consumed by the transfer
    p_arm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cycle && st_q.armed && !ldok_set) |=> !st_q.armed);

endmodule

// File: rtl/pwm_cmp_stage.sv
module pwm_cmp_stage
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [CNT_W-1:0] val_even,
    input  logic [CNT_W-1:0] val_odd,
    output logic             even_p,
    output logic             odd_p
);

    raw_pulse_t rp_d, rp_q;

    always_comb begin
        rp_d.even_p = (cnt_in >= val_even);
        rp_d.odd_p  = (cnt_in >= val_odd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign even_p = rp_q.even_p;
    assign odd_p  = rp_q.odd_p;

endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gen,
    input  logic            lo_indep,
    input  logic            compl_mode,
    input  logic            mask,
    input  logic [DT_W-1:0] deadtime,
    output logic            out_hi,
    output logic            out_lo
);

    localparam logic [DT_W-1:0] GAP_MAX = {DT_W{1'b1}};

    typedef struct packed {
        logic            hi;
        logic            lo;
        logic [DT_W-1:0] gap;
    } dt_state_t;

    dt_state_t st_d, st_q;
    logic      gap_ok;

    always_comb begin
        st_d   = st_q;
        gap_ok = (st_q.gap >= deadtime);
        if (compl_mode) begin
            st_d.hi = gen && !st_q.lo && gap_ok;
            st_d.lo = !gen && !st_q.hi && gap_ok;
        end else begin
            st_d.hi = gen;
            st_d.lo = lo_indep;
        end
        if (st_d.hi || st_d.lo) begin
            st_d.gap = '0;
        end else if (st_q.gap != GAP_MAX) begin
            st_d.gap = st_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_hi = st_q.hi;
    assign out_lo = st_q.lo;

    // R10: never both on
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hi && st_q.lo));

    // R8: high side rises only after the low side was off
    p_hi_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.hi) && $past(compl_mode)) |-> $past(!st_q.lo));

    // R9: masking in complementary mode keeps the high side off
    p_mask_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && compl_mode) |=> !st_q.hi);

    // R9: masking in independent mode keeps both off
    p_mask_ind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !compl_mode) |=> (!st_q.hi && !st_q.lo));

endmodule

// File: rtl/pwm_xor_pair.sv
module pwm_xor_pair #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [CNT_W-1:0] val_even,
    input  logic [CNT_W-1:0] val_odd,
    input  logic             xor_wr,
    input  logic             xor_wdata,
    input  logic             ldok_set,
    input  logic             load_cycle,
    input  logic             compl_mode,
    input  logic             mask,
    input  logic [DT_W-1:0]  deadtime,
    output logic             out_hi,
    output logic             out_lo,
    output logic             xor_rdbk
);

    logic even_p, odd_p, act_bit;
    logic gen, lo_indep;

    pwm_edge_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .xor_wr     (xor_wr),
        .xor_wdata  (xor_wdata),
        .ldok_set   (ldok_set),
        .load_cycle (load_cycle),
        .buf_bit    (xor_rdbk),
        .act_bit    (act_bit)
    );

    pwm_cmp_stage #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_in   (cnt_in),
        .val_even (val_even),
        .val_odd  (val_odd),
        .even_p   (even_p),
        .odd_p    (odd_p)
    );

    // Pulse combining ahead of the complementary split
    always_comb begin
        if (mask) begin
            gen = 1'b0;
        end else if (compl_mode && act_bit) begin
            gen = even_p ^ odd_p;
        end else begin
            gen = even_p && !odd_p;
        end
        lo_indep = odd_p && !mask;
    end

    pwm_deadtime #(.DT_W(DT_W)) u_dt (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen        (gen),
        .lo_indep   (lo_indep),
        .compl_mode (compl_mode),
        .mask       (mask),
        .deadtime   (deadtime),
        .out_hi     (out_hi),
        .out_lo     (out_lo)
    );

    // R4: independent mode passes the odd pulse straight to the low side
    p_indep_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!compl_mode && !mask) |=> (out_lo == $past(odd_p)));

endmodule

// File: tb/pwm_xor_pair_test.sv
module pwm_xor_pair_test;

    localparam int CNT_W = 16;
    localparam int DT_W  = 8;
    localparam int PER   = 40;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] cnt_in, val_even, val_odd;
    logic             xor_wr, xor_wdata, ldok_set, load_cycle, compl_mode, mask;
    logic [DT_W-1:0]  deadtime;
    logic             out_hi, out_lo, xor_rdbk;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string tag    = "R1";
    bit    req_wr = 1'b0, req_wd = 1'b0, req_ld = 1'b0;

    always #2.5 clk = ~clk;

    pwm_xor_pair #(.CNT_W(CNT_W), .DT_W(DT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .val_even(val_even),
        .val_odd(val_odd), .xor_wr(xor_wr), .xor_wdata(xor_wdata),
        .ldok_set(ldok_set), .load_cycle(load_cycle), .compl_mode(compl_mode),
        .mask(mask), .deadtime(deadtime), .out_hi(out_hi), .out_lo(out_lo),
        .xor_rdbk(xor_rdbk)
    );

    typedef struct {
        logic  hi;
        logic  lo;
        logic  rd;
        string rq;
    } exp_t;
    exp_t sb[$];

    // Expectation model built from the requirement text
    logic            m_e, m_o, m_buf, m_arm, m_act, m_hi, m_lo;
    int              m_gap;
    always @(posedge clk) begin
        logic g, nh, nl;
        exp_t x;
        if (!rst_n) begin
            m_e = 0; m_o = 0; m_buf = 0; m_arm = 0; m_act = 0;
            m_hi = 0; m_lo = 0; m_gap = 0;
        end else begin
            if (mask) g = 1'b0;                       // R9
            else if (compl_mode && m_act) g = m_e ^ m_o; // R3
            else g = m_e && !m_o;                     // R2
            if (compl_mode) begin                     // R8
                nh = g && !m_lo && (m_gap >= int'(deadtime));
                nl = !g && !m_hi && (m_gap >= int'(deadtime));
            end else begin                            // R4
                nh = g;
                nl = m_o && !mask;
            end
            m_hi = nh; m_lo = nl;
            if (nh || nl) m_gap = 0;
            else if (m_gap < 255) m_gap = m_gap + 1;
            if (load_cycle && m_arm) begin            // R6, R7
                m_act = m_buf;
                m_arm = 1'b0;
            end
            if (ldok_set) m_arm = 1'b1;
            if (xor_wr) m_buf = xor_wdata;            // R5
            m_e = (cnt_in >= val_even);
            m_o = (cnt_in >= val_odd);
        end
        x.hi = m_hi; x.lo = m_lo; x.rd = m_buf; x.rq = tag;
        sb.push_back(x);
    end

    // Monitor: compares away from the active edge
    always @(negedge clk) begin
        exp_t x;
        if (!done && sb.size() > 0) begin
            x = sb.pop_front();
            checks++;
            if (out_hi !== x.hi || out_lo !== x.lo || xor_rdbk !== x.rd) begin
                errors++;
                $display("FAIL %s: hi/lo/rd actual %b%b%b expected %b%b%b at %0t",
                         x.rq, out_hi, out_lo, xor_rdbk, x.hi, x.lo, x.rd, $time);
            end
            checks++;
            if (out_hi === 1'b1 && out_lo === 1'b1) begin
                errors++;
                $display("FAIL R10: hi/lo actual 11 expected not both high at %0t", $time);
            end
        end
    end

    task automatic run_periods(input string t, input int n);
        tag = t;
        for (int p = 0; p < n; p++) begin
            for (int c = 0; c < PER; c++) begin
                @(negedge clk);
                cnt_in     = CNT_W'(c);
                load_cycle = (c == PER - 1);
                xor_wr     = req_wr;
                xor_wdata  = req_wd;
                ldok_set   = req_ld;
                req_wr = 1'b0;
                req_ld = 1'b0;
            end
        end
    endtask

    task automatic direct_check(input string t, input logic a, input logic e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", t, a, e);
        end
    endtask

    initial begin
        rst_n = 0; cnt_in = '0; val_even = '0; val_odd = '0;
        xor_wr = 0; xor_wdata = 0; ldok_set = 0; load_cycle = 0;
        compl_mode = 0; mask = 0; deadtime = '0;
        repeat (3) @(negedge clk);
        direct_check("R1 hi", out_hi, 1'b0);
        direct_check("R1 lo", out_lo, 1'b0);
        direct_check("R1 rd", xor_rdbk, 1'b0);
        rst_n = 1;
        // R4: independent drive
        val_even = 10; val_odd = 25; deadtime = 2;
        run_periods("R4", 2);
        // R2 and R8: complementary, plain generation
        compl_mode = 1; deadtime = 0; val_even = 5; val_odd = 30;
        run_periods("R2", 2);
        deadtime = 3;
        run_periods("R8", 2);
        deadtime = 7;
        run_periods("R8", 1);
        // R5: buffered write, active copy untouched (even above odd)
        val_even = 30; val_odd = 10; deadtime = 2;
        req_wr = 1; req_wd = 1;
        run_periods("R5", 1);
        direct_check("R5 rd", xor_rdbk, 1'b1);
        run_periods("R6", 1);      // unarmed load cycle: no transfer
        req_ld = 1;
        run_periods("R6", 1);      // armed load cycle at period end
        run_periods("R3", 2);      // combining active: pulse from 10 to 30
        // R7: arming consumed, new buffered value stays pending
        req_wr = 1; req_wd = 0;
        run_periods("R7", 2);
        req_ld = 1;
        run_periods("R7", 2);
        // R9: mask in both modes
        mask = 1;
        run_periods("R9", 1);
        compl_mode = 0;
        run_periods("R9", 1);
        mask = 0;
        // R4: combining bit ignored in independent mode
        req_wr = 1; req_wd = 1; req_ld = 1;
        run_periods("R4", 1);
        run_periods("R4", 1);
        compl_mode = 1;
        run_periods("R3", 1);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule